// File: doc/BRIEF.md
# Three-Wire Addressed Control Receiver

This block is a write-only slave on a three-line control bus driven by a microcontroller: a mode line, a bus clock and a data line. Each burst of eight bus-clock pulses carries one byte. With the mode line low the byte is an address byte: its upper six bits name a device and its lower two bits choose which register bank later bytes go to. With the mode line high the byte is a data byte, and it is written into the chosen bank only while this device is selected.

The receiver runs entirely from the chip's system clock. The three bus lines pass through synchronizer flops and the bus clock is edge-detected in the system domain, so the bus must be slow compared with the system clock. It holds four tone and volume fields and two seven-bit control words, all presented as parallel outputs, plus a decoded lock-length value taken from the second control word.

Top module: `ctl3w_rx`

## Requirements
- R1: A byte is assembled from eight rising edges of `cb_clk`. The first bit received lands in bit 0 and the last in bit 7. The level of `cb_mode` during the byte decides its kind: low means address byte, high means data byte.
- R2: An address byte whose bits 7..2 equal `DEV_ADDR` (default 6'b000101, bit 7 the MSB) selects the device. Any other value deselects it, and data bytes are then ignored. An address byte never changes any output.
- R3: The selection and transfer type stay in force for any number of following data bytes until the next address byte.
- R4: Address bits 1..0 give the transfer type. 2'b00 is the tone/volume bank and 2'b10 is the control bank. With 2'b01 or 2'b11, data bytes change no output.
- R5: A register changes only once the eighth bit of a data byte has arrived. Outputs are constant while a byte is partly received.
- R6: In the tone/volume bank, data bits 7..6 pick the target. 2'b00 writes bits 5..0 to `vol_right`. 2'b01 writes bits 5..0 to `vol_left`. 2'b10 writes bits 4..0 to `bass_lvl`. 2'b11 writes bits 4..0 to `treble_lvl`.
- R7: In the control bank, data bit 7 = 0 writes bits 6..0 to `ctrl0` and bit 7 = 1 writes bits 6..0 to `ctrl1`. The fields of `ctrl0` are: bit 0 reset, bit 1 soft mute, bit 2 sync/async, bit 3 channel swap, bit 4 de-emphasis, bits 6..5 audio mode.
- R8: `lock_len` decodes `ctrl1` bits 6..5. 2'b00 gives 512, 2'b01 gives 2048, 2'b10 gives 4096 and 2'b11 gives 16384.
- R9: When `cb_mode` changes in the middle of a byte, the partial byte is thrown away and the bit count restarts. A rising edge of `cb_clk` seen in the same cycle as the change counts as bit 0 of the new byte.
- R10: After reset all outputs are zero except `lock_len`, which is 512. The device is deselected, so data bytes sent before any address byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cb_mode | input | 1 | Bus mode line: low for address, high for data |
| cb_clk | input | 1 | Bus clock; data sampled on its rising edge |
| cb_data | input | 1 | Bus serial data, bit 0 first |
| vol_right | output | 6 | Right volume field |
| vol_left | output | 6 | Left volume field |
| bass_lvl | output | 5 | Bass field |
| treble_lvl | output | 5 | Treble field |
| ctrl0 | output | 7 | Control word 0 |
| ctrl1 | output | 7 | Control word 1 |
| lock_len | output | 15 | Lock length in samples decoded from ctrl1 |

## Verification
A mode-line change and a bus-clock rising edge can be seen in the same synchronized cycle. In that case the partial-byte flush and the capture of a new first bit happen together. The bench provokes this by switching the mode line from data to address at the same instant as the first clock rise of an address byte, after three stray data bits. The reference model judges it by requiring the resulting eight bits to decode as a clean selecting address, with the following data byte landing in the right register and no register changed by the stray bits.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 6;
    localparam int VOL_W    = 6;
    localparam int TONE_W   = 5;
    localparam int CTRL_W   = 7;
    localparam int LOCK_W   = 15;
    localparam int BITCNT_W = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        XT_TONE  = 2'b00,
        XT_NONE1 = 2'b01,
        XT_CTRL  = 2'b10,
        XT_NONE3 = 2'b11
    } xfer_t;

    typedef struct packed {
        logic              sel;
        xfer_t             xt;
        logic [VOL_W-1:0]  vr;
        logic [VOL_W-1:0]  vl;
        logic [TONE_W-1:0] bass;
        logic [TONE_W-1:0] treb;
        logic [CTRL_W-1:0] c0;
        logic [CTRL_W-1:0] c1;
    } bank_t;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
    import ctl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_mode,
    input  logic              s_clk,
    input  logic              s_data,
    output logic              byte_vld,
    output logic              byte_is_addr,
    output logic [BYTE_W-1:0] byte_val,
    output logic              mode_chg
);
    typedef struct packed {
        logic [BYTE_W-1:0]   sr;
        logic [BITCNT_W-1:0] cnt;
        logic                mode;
        logic                clk_last;
        logic                vld;
        logic                is_addr;
    } shf_t;

    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

    shf_t                s_d, s_q;
    logic [BITCNT_W-1:0] cnt_base;

    always_comb begin
        s_d          = s_q;
        s_d.vld      = 1'b0;
        s_d.clk_last = s_clk;
        s_d.mode     = s_mode;
        mode_chg     = (s_mode != s_q.mode);
        cnt_base     = mode_chg ? '0 : s_q.cnt;
        s_d.cnt      = cnt_base;
        if (s_clk && !s_q.clk_last) begin
            s_d.sr = {s_data, s_q.sr[BYTE_W-1:1]};
            if (cnt_base == LAST_BIT) begin
                s_d.cnt     = '0;
                s_d.vld     = 1'b1;
                s_d.is_addr = ~s_mode;
            end else begin
                s_d.cnt = cnt_base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_vld     = s_q.vld;
    assign byte_is_addr = s_q.is_addr;
    assign byte_val     = s_q.sr;
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
    import ctl3w_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_is_addr,
    input  logic [BYTE_W-1:0] byte_val,
    output bank_t             bank,
    output logic [LOCK_W-1:0] lock_len
);
    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (byte_vld) begin
            if (byte_is_addr) begin
                b_d.sel = (byte_val[BYTE_W-1 -: ADDR_W] == DEV_ADDR);
                b_d.xt  = xfer_t'(byte_val[1:0]);
            end else if (b_q.sel) begin
                case (b_q.xt)
                    XT_TONE: begin
                        case (byte_val[7:6])
                            2'b00:   b_d.vr   = byte_val[VOL_W-1:0];
                            2'b01:   b_d.vl   = byte_val[VOL_W-1:0];
                            2'b10:   b_d.bass = byte_val[TONE_W-1:0];
                            default: b_d.treb = byte_val[TONE_W-1:0];
                        endcase
                    end
                    XT_CTRL: begin
                        if (byte_val[7]) b_d.c1 = byte_val[CTRL_W-1:0];
                        else             b_d.c0 = byte_val[CTRL_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    always_comb begin
        case (b_q.c1[6:5])
            2'b00:   lock_len = LOCK_W'(512);
            2'b01:   lock_len = LOCK_W'(2048);
            2'b10:   lock_len = LOCK_W'(4096);
            default: lock_len = LOCK_W'(16384);
        endcase
    end

    assign bank = b_q;
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
    import ctl3w_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 6'b000101,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cb_mode,
    input  logic              cb_clk,
    input  logic              cb_data,
    output logic [VOL_W-1:0]  vol_right,
    output logic [VOL_W-1:0]  vol_left,
    output logic [TONE_W-1:0] bass_lvl,
    output logic [TONE_W-1:0] treble_lvl,
    output logic [CTRL_W-1:0] ctrl0,
    output logic [CTRL_W-1:0] ctrl1,
    output logic [LOCK_W-1:0] lock_len
);
    logic [2:0]        sync_q;
    logic              byte_vld, byte_is_addr, mode_chg;
    logic [BYTE_W-1:0] byte_val;
    bank_t             bank;

    ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cb_mode, cb_clk, cb_data}),
        .q     (sync_q)
    );

    ctl3w_shift u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_mode       (sync_q[2]),
        .s_clk        (sync_q[1]),
        .s_data       (sync_q[0]),
        .byte_vld     (byte_vld),
        .byte_is_addr (byte_is_addr),
        .byte_val     (byte_val),
        .mode_chg     (mode_chg)
    );

    ctl3w_regs #(.DEV_ADDR(DEV_ADDR)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld     (byte_vld),
        .byte_is_addr (byte_is_addr),
        .byte_val     (byte_val),
        .bank         (bank),
        .lock_len     (lock_len)
    );

    assign vol_right  = bank.vr;
    assign vol_left   = bank.vl;
    assign bass_lvl   = bank.bass;
    assign treble_lvl = bank.treb;
    assign ctrl0      = bank.c0;
    assign ctrl1      = bank.c1;
endmodule

// File: rtl/ctl3w_rx_chk.sv
module ctl3w_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        byte_vld,
    input logic        byte_is_addr,
    input logic        mode_chg,
    input logic [5:0]  vol_right,
    input logic [5:0]  vol_left,
    input logic [4:0]  bass_lvl,
    input logic [4:0]  treble_lvl,
    input logic [6:0]  ctrl0,
    input logic [6:0]  ctrl1,
    input logic [14:0] lock_len
);
    logic [35:0] regs_all;
    assign regs_all = {vol_right, vol_left, bass_lvl, treble_lvl, ctrl0, ctrl1};

    // R10: zero state right after reset release
    a_r10_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (regs_all == '0));

    // R5: outputs move only on a completed byte
    a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(regs_all));

    // R2: an address byte writes no register
    a_r2_addr_writes_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_is_addr) |=> $stable(regs_all));

    // R9: a mode change never completes a byte
    a_r9_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !byte_vld);

    // R8: lock length is one of the power-of-two values
    a_r8_lock_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lock_len) == 1);
endmodule

bind ctl3w_rx ctl3w_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (byte_vld),
    .byte_is_addr (byte_is_addr),
    .mode_chg     (mode_chg),
    .vol_right    (vol_right),
    .vol_left     (vol_left),
    .bass_lvl     (bass_lvl),
    .treble_lvl   (treble_lvl),
    .ctrl0        (ctrl0),
    .ctrl1        (ctrl1),
    .lock_len     (lock_len)
);

// File: tb/sim_ctl3w_rx.sv
module sim_ctl3w_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cb_mode = 1'b0, cb_clk = 1'b0, cb_data = 1'b0;
    logic [5:0]  vol_right, vol_left;
    logic [4:0]  bass_lvl, treble_lvl;
    logic [6:0]  ctrl0, ctrl1;
    logic [14:0] lock_len;

    int n_chk = 0, n_fail = 0;
    bit settled = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    bit     m_sel = 0;
    int     m_type = 0;
    int     m_vr = 0, m_vl = 0, m_bass = 0, m_treb = 0, m_c0 = 0, m_c1 = 0;

    always #2.5ns clk = ~clk;

    ctl3w_rx u0 (
        .clk(clk), .rst_n(rst_n), .cb_mode(cb_mode), .cb_clk(cb_clk), .cb_data(cb_data),
        .vol_right(vol_right), .vol_left(vol_left), .bass_lvl(bass_lvl),
        .treble_lvl(treble_lvl), .ctrl0(ctrl0), .ctrl1(ctrl1), .lock_len(lock_len)
    );

    function automatic int lock_of(int c1);
        case ((c1 >> 5) & 3)
            0: return 512;
            1: return 2048;
            2: return 4096;
            default: return 16384;
        endcase
    endfunction

    function automatic void model_byte(bit is_addr, int b);
        if (is_addr) begin
            m_sel  = (((b >> 2) & 63) == 5);
            m_type = b & 3;
        end else if (m_sel) begin
            if (m_type == 0) begin
                case ((b >> 6) & 3)
                    0: m_vr = b & 63;
                    1: m_vl = b & 63;
                    2: m_bass = b & 31;
                    default: m_treb = b & 31;
                endcase
            end else if (m_type == 2) begin
                if (b & 128) m_c1 = b & 127;
                else         m_c0 = b & 127;
            end
        end
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference compared on every clock once the bus is quiet
    always @(negedge clk) begin
        if (settled && !done) begin
            check("R6 vol_right", int'(vol_right), m_vr);
            check("R6 vol_left", int'(vol_left), m_vl);
            check("R6 bass", int'(bass_lvl), m_bass);
            check("R6 treble", int'(treble_lvl), m_treb);
            check("R7 ctrl0", int'(ctrl0), m_c0);
            check("R7 ctrl1", int'(ctrl1), m_c1);
            check("R8 lock_len", int'(lock_len), lock_of(m_c1));
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(bit m, bit d, bit mode_at_rise);
        if (!mode_at_rise) cb_mode = m;
        cb_data = d;
        wait_n(4);
        if (mode_at_rise) cb_mode = m;
        cb_clk = 1'b1;
        wait_n(4);
        cb_clk = 1'b0;
    endtask

    // m = 0 address, 1 data; late = mode switches with the first rising edge
    task automatic send_byte(bit m, int b, bit late);
        for (int i = 0; i < 8; i++) begin
            if (i == 7) settled = 1'b0;
            put_bit(m, b[i], late && (i == 0));
        end
        wait_n(8);
        model_byte(!m, b);
        settled = 1'b1;
    endtask

    task automatic send_partial(bit m, int b, int nbits);
        for (int i = 0; i < nbits; i++) put_bit(m, b[i], 1'b0);
    endtask

    initial begin
        wait_n(4);
        check("R10 reset vol_right", int'(vol_right), 0);
        check("R10 reset ctrl0", int'(ctrl0), 0);
        check("R10 reset lock_len", int'(lock_len), 512);
        rst_n = 1'b1;
        wait_n(3);
        settled = 1'b1;

        // R10: data byte while deselected after reset
        send_byte(1, 8'h3F, 0);
        check("R10 ignored before address", int'(vol_right), 0);

        // R1 R6 R3: tone bank, several bytes under one address
        send_byte(0, 8'h14, 0);
        send_byte(1, 8'h2A, 0);
        check("R6 right volume", int'(vol_right), 6'h2A);
        send_byte(1, 8'h55, 0);
        check("R3 left volume after second byte", int'(vol_left), 6'h15);
        send_byte(1, 8'h9B, 0);
        check("R6 bass", int'(bass_lvl), 5'h1B);
        send_byte(1, 8'hE7, 0);
        check("R6 treble", int'(treble_lvl), 5'h07);
        check("R1 bit order right volume kept", int'(vol_right), 6'h2A);

        // R7 R8: control bank
        send_byte(0, 8'h16, 0);
        send_byte(1, 8'h63, 0);
        check("R7 ctrl0 fields", int'(ctrl0), 7'h63);
        send_byte(1, 8'hC0, 0);
        check("R8 lock 4096", int'(lock_len), 4096);
        send_byte(1, 8'hA0, 0);
        check("R8 lock 2048", int'(lock_len), 2048);
        send_byte(1, 8'hE0, 0);
        check("R8 lock 16384", int'(lock_len), 16384);
        send_byte(1, 8'h80, 0);
        check("R8 lock 512", int'(lock_len), 512);
        check("R7 ctrl0 untouched by ctrl1 write", int'(ctrl0), 7'h63);

        // R4: unused transfer types
        send_byte(0, 8'h15, 0);
        send_byte(1, 8'h11, 0);
        send_byte(1, 8'h91, 0);
        check("R4 type 01 writes nothing", int'(vol_right), 6'h2A);
        send_byte(0, 8'h17, 0);
        send_byte(1, 8'h05, 0);
        check("R4 type 11 writes nothing", int'(ctrl0), 7'h63);

        // R2: foreign address deselects
        send_byte(0, 8'h24, 0);
        send_byte(1, 8'h01, 0);
        check("R2 foreign address ignored", int'(vol_right), 6'h2A);

        // R5 R9: partial data byte then a mode change to a clean address
        send_byte(0, 8'h14, 0);
        send_partial(1, 8'h0C, 5);
        wait_n(10);
        check("R5 partial byte no write", int'(vol_right), 6'h2A);
        send_byte(0, 8'h14, 0);
        send_byte(1, 8'h0C, 0);
        check("R9 after flush", int'(vol_right), 6'h0C);

        // R9: mode change coincides with first rising edge
        send_partial(1, 8'h3F, 3);
        send_byte(0, 8'h16, 1);
        send_byte(1, 8'h1E, 0);
        check("R9 coincident edge selects control bank", int'(ctrl0), 7'h1E);
        check("R9 stray bits wrote nothing", int'(vol_right), 6'h0C);

        wait_n(5);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule